// File: doc/BRIEF.md
# Phase Comparator with Digital Lock Detector

This block sits between the two dividers of a frequency synthesizer loop and the analog charge pump. It is clocked by the reference oscillator and receives two single-cycle pulses: the divided reference event and the divided feedback event. It decides which one arrived first and by how many oscillator clocks, then opens a drive window of that length on a three-state charge-pump command. The window drives high, drives low, or leaves the pin floating. A polarity bit swaps the two drive directions, which suits loop filters and oscillators of either slope.

A lock detector follows the same comparisons. It measures each phase error in oscillator clocks and applies hysteresis. A single large error drops the flag at once. Three consecutive small errors in a row are needed to raise it again. One shared pin shows either the lock flag or one of the two divided pulses, chosen by a select bit.

A power-save input floats the pump command and holds the lock flag high. When power save is released, the first comparison is swallowed, so that the unknown phase left over from the pause cannot kick the oscillator. The current-select bit for the analog pump is only carried through the block.

Top module: `phase_lock_cmp`

## Requirements
- R1: With `pol_fc`=1, a reference pulse that comes k clocks (k>=1) before the feedback pulse drives the pin high (`cp_oe`=1, `cp_lvl`=1) for exactly k clocks. A feedback pulse that comes k clocks first drives it low (`cp_oe`=1, `cp_lvl`=0) for k clocks.
- R2: With `pol_fc`=0, the two drive directions of R1 are swapped: a leading reference pulse drives low and a leading feedback pulse drives high, each for k clocks.
- R3: When both pulses arrive in the same clock, the pin stays floating (`cp_oe`=0). Both `pump_up` and `pump_dn` are asserted together for exactly one clock; this is the dead-zone pulse.
- R4: Outside a drive window the pin floats (`cp_oe`=0). After reset `cp_oe`=0.
- R5: With `mon_sel`=1, `ld_mon` shows the reference pulse input delayed by one clock when `pol_fc`=1, and the feedback pulse input delayed by one clock when `pol_fc`=0.
- R6: With `mon_sel`=0, `ld_mon` shows the lock flag: 1 locked, 0 unlocked. The flag is 0 after reset.
- R7: The lock flag falls as soon as a pending lead reaches 3 clocks, without waiting for the lagging pulse.
- R8: The lock flag rises only after three consecutive comparisons, each with an error of at most 2 clocks. A comparison with an error of 3 or more restarts the count.
- R9: While `pwr_save`=1, the pin floats, no pump pulse appears and `ld_mon` (with `mon_sel`=0) is 1. The flag is still 1 after release, until an error is seen.
- R10: After `pwr_save` is released, the first completed comparison produces no pump pulse and does not change the lock flag. The next comparison acts normally.
- R11: `cs_out` always equals `cs_in`.
- R12: A second reference pulse that arrives while a reference lead is pending does not restart the measurement. The window runs from the first pulse until the feedback pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_in | input | 1 | Divided reference event, one clock wide |
| fp_in | input | 1 | Divided feedback event, one clock wide |
| pol_fc | input | 1 | Pump polarity (1: leading reference drives high) |
| mon_sel | input | 1 | Shared pin select (1: pulse monitor, 0: lock flag) |
| pwr_save | input | 1 | Power save, active high |
| cs_in | input | 1 | Pump current select, passed through |
| pump_up | output | 1 | Switch command driving the pin high |
| pump_dn | output | 1 | Switch command driving the pin low |
| cp_oe | output | 1 | Pin driven (1) or floating (0) |
| cp_lvl | output | 1 | Pin level when driven |
| ld_mon | output | 1 | Lock flag or pulse monitor |
| cs_out | output | 1 | Copy of `cs_in` |

## Verification
Two functions meet on one clock edge in this block. The first pair is the end of the wake-up discard and the completion of the first comparison after power save. The bench releases `pwr_save` and then runs a 4-clock lead. It expects no pulse and an unchanged flag, then a normal 4-clock pulse from the following comparison. The second pair is the early unlock firing on the same edge where a 3-clock lag completes. That comparison is run while relocking, and the bench expects the count to restart with both the pulse width and the flag correct.

// File: rtl/phase_lock_cmp_pkg.sv
package phase_lock_cmp_pkg;

    localparam int PHASE_CNT_W = 6;

    typedef logic [PHASE_CNT_W-1:0] phase_cnt_t;

    typedef enum logic [1:0] {
        RACE_IDLE = 2'd0,
        RACE_FR   = 2'd1,
        RACE_FP   = 2'd2
    } race_st_e;

    typedef struct packed {
        logic       done;
        logic       both;
        phase_cnt_t err;
    } cmp_result_t;

    function automatic phase_cnt_t cnt_sat_inc(input phase_cnt_t v);
        return (&v) ? v : v + phase_cnt_t'(1);
    endfunction

endpackage

// File: rtl/pfd_edge_race.sv
module pfd_edge_race
    import phase_lock_cmp_pkg::*;
#(
    parameter int UNLOCK_TH = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold,
    input  logic        fr_in,
    input  logic        fp_in,
    output race_st_e    st,
    output phase_cnt_t  cnt,
    output cmp_result_t res,
    output logic        overdue
);
    race_st_e   st_nxt;
    phase_cnt_t cnt_nxt;

    always_comb begin
        st_nxt   = st;
        cnt_nxt  = cnt;
        res      = '0;
        if (hold) begin
            st_nxt  = RACE_IDLE;
            cnt_nxt = '0;
        end else begin
            case (st)
                RACE_IDLE: begin
                    if (fr_in && fp_in) begin
                        res.done = 1'b1;
                        res.both = 1'b1;
                    end else if (fr_in) begin
                        st_nxt  = RACE_FR;
                        cnt_nxt = phase_cnt_t'(1);
                    end else if (fp_in) begin
                        st_nxt  = RACE_FP;
                        cnt_nxt = phase_cnt_t'(1);
                    end
                end
                RACE_FR: begin
                    if (fp_in) begin
                        res.done = 1'b1;
                        res.err  = cnt;
                        st_nxt   = fr_in ? RACE_FR : RACE_IDLE;
                        cnt_nxt  = fr_in ? phase_cnt_t'(1) : '0;
                    end else begin
                        cnt_nxt = cnt_sat_inc(cnt);
                    end
                end
                RACE_FP: begin
                    if (fr_in) begin
                        res.done = 1'b1;
                        res.err  = cnt;
                        st_nxt   = fp_in ? RACE_FP : RACE_IDLE;
                        cnt_nxt  = fp_in ? phase_cnt_t'(1) : '0;
                    end else begin
                        cnt_nxt = cnt_sat_inc(cnt);
                    end
                end
                default: begin
                    st_nxt  = RACE_IDLE;
                    cnt_nxt = '0;
                end
            endcase
        end
    end

    assign overdue = (st != RACE_IDLE) && (int'(cnt) >= UNLOCK_TH);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= RACE_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/pfd_pump_drive.sv
module pfd_pump_drive
    import phase_lock_cmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        save,
    input  logic        discard,
    input  logic        pol,
    input  race_st_e    st,
    input  cmp_result_t res,
    output logic        pump_up,
    output logic        pump_dn,
    output logic        cp_oe,
    output logic        cp_lvl
);
    logic bal_q;
    logic fr_drv;
    logic fp_drv;
    logic quiet;

    always_ff @(posedge clk) begin
        if (rst) bal_q <= 1'b0;
        else     bal_q <= !save && !discard && res.done && res.both;
    end

    assign quiet  = save || discard;
    assign fr_drv = !quiet && ((st == RACE_FR) || bal_q);
    assign fp_drv = !quiet && ((st == RACE_FP) || bal_q);

    assign pump_up = pol ? fr_drv : fp_drv;
    assign pump_dn = pol ? fp_drv : fr_drv;
    assign cp_oe   = pump_up ^ pump_dn;
    assign cp_lvl  = pump_up;
endmodule

// File: rtl/pfd_lock_track.sv
module pfd_lock_track
    import phase_lock_cmp_pkg::*;
#(
    parameter int UNLOCK_TH = 3,
    parameter int LOCK_TH   = 2,
    parameter int LOCK_CYC  = 3,
    parameter int GOOD_W    = $clog2(LOCK_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              save,
    input  logic              overdue,
    input  cmp_result_t       res,
    output logic              lock_q,
    output logic              discard,
    output logic [GOOD_W-1:0] good_cnt
);
    localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(LOCK_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q   <= 1'b0;
            discard  <= 1'b0;
            good_cnt <= '0;
        end else if (save) begin
            lock_q   <= 1'b1;
            discard  <= 1'b1;
            good_cnt <= '0;
        end else begin
            if (res.done) discard <= 1'b0;
            if (!discard) begin
                if (overdue) begin
                    lock_q   <= 1'b0;
                    good_cnt <= '0;
                end else if (res.done) begin
                    if (int'(res.err) >= UNLOCK_TH) begin
                        lock_q   <= 1'b0;
                        good_cnt <= '0;
                    end else if (int'(res.err) <= LOCK_TH) begin
                        if (int'(good_cnt) + 1 >= LOCK_CYC) begin
                            lock_q   <= 1'b1;
                            good_cnt <= GOOD_TOP;
                        end else begin
                            good_cnt <= good_cnt + GOOD_W'(1);
                        end
                    end else begin
                        good_cnt <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pfd_mon_mux.sv
module pfd_mon_mux (
    input  logic clk,
    input  logic rst,
    input  logic fr_in,
    input  logic fp_in,
    input  logic pol,
    input  logic sel,
    input  logic save,
    input  logic lock_q,
    output logic ld_mon
);
    logic fr_q;
    logic fp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q <= 1'b0;
            fp_q <= 1'b0;
        end else begin
            fr_q <= fr_in;
            fp_q <= fp_in;
        end
    end

    assign ld_mon = sel ? (pol ? fr_q : fp_q) : (save || lock_q);
endmodule

// File: rtl/phase_lock_cmp.sv
module phase_lock_cmp
    import phase_lock_cmp_pkg::*;
#(
    parameter int UNLOCK_TH = 3,
    parameter int LOCK_TH   = 2,
    parameter int LOCK_CYC  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fr_in,
    input  logic fp_in,
    input  logic pol_fc,
    input  logic mon_sel,
    input  logic pwr_save,
    input  logic cs_in,
    output logic pump_up,
    output logic pump_dn,
    output logic cp_oe,
    output logic cp_lvl,
    output logic ld_mon,
    output logic cs_out
);
    localparam int GOOD_W = $clog2(LOCK_CYC + 1);

    race_st_e          race_st;
    phase_cnt_t        race_cnt;
    cmp_result_t       cmp_res;
    logic              overdue;
    logic              lock_flag;
    logic              discard;
    logic [GOOD_W-1:0] good_cnt;

    pfd_edge_race #(.UNLOCK_TH(UNLOCK_TH)) u_race (
        .clk(clk), .rst(rst), .hold(pwr_save),
        .fr_in(fr_in), .fp_in(fp_in),
        .st(race_st), .cnt(race_cnt), .res(cmp_res), .overdue(overdue)
    );

    pfd_pump_drive u_pump (
        .clk(clk), .rst(rst), .save(pwr_save), .discard(discard),
        .pol(pol_fc), .st(race_st), .res(cmp_res),
        .pump_up(pump_up), .pump_dn(pump_dn), .cp_oe(cp_oe), .cp_lvl(cp_lvl)
    );

    pfd_lock_track #(
        .UNLOCK_TH(UNLOCK_TH), .LOCK_TH(LOCK_TH),
        .LOCK_CYC(LOCK_CYC), .GOOD_W(GOOD_W)
    ) u_lock (
        .clk(clk), .rst(rst), .save(pwr_save), .overdue(overdue),
        .res(cmp_res), .lock_q(lock_flag), .discard(discard),
        .good_cnt(good_cnt)
    );

    pfd_mon_mux u_mon (
        .clk(clk), .rst(rst), .fr_in(fr_in), .fp_in(fp_in),
        .pol(pol_fc), .sel(mon_sel), .save(pwr_save),
        .lock_q(lock_flag), .ld_mon(ld_mon)
    );

    assign cs_out = cs_in;
endmodule

// File: rtl/phase_lock_cmp_chk.sv
module phase_lock_cmp_chk
    import phase_lock_cmp_pkg::*;
#(
    parameter int UNLOCK_TH = 3,
    parameter int LOCK_CYC  = 3,
    parameter int GOOD_W    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              fr_in,
    input logic              fp_in,
    input logic              pol_fc,
    input logic              mon_sel,
    input logic              pwr_save,
    input logic              pump_up,
    input logic              pump_dn,
    input logic              cp_oe,
    input logic              ld_mon,
    input logic              overdue,
    input logic              discard,
    input logic              lock_q,
    input logic [GOOD_W-1:0] good_cnt
);
    // R3: a dead-zone pulse only follows a same-clock arrival of both inputs
    assert_deadzone_src_R3: assert property (@(posedge clk) disable iff (rst)
        (pump_up && pump_dn) |-> $past(fr_in && fp_in));

    // R5: the monitor follows the reference input one clock later
    assert_monitor_fr_R5: assert property (@(posedge clk) disable iff (rst)
        (mon_sel && pol_fc && !$past(rst)) |-> (ld_mon == $past(fr_in)));

    // R7: a pending lead of the unlock length clears the flag on the next edge
    assert_early_unlock_R7: assert property (@(posedge clk) disable iff (rst)
        (overdue && !discard && !pwr_save) |=> !lock_q);

    // R8: the flag rises only from a full run of good comparisons
    assert_lock_run_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(lock_q) && !$past(pwr_save)) |-> (int'($past(good_cnt)) == LOCK_CYC - 1));

    // R9: power save floats the pin and leaves the flag set
    assert_save_float_R9: assert property (@(posedge clk) disable iff (rst)
        (pwr_save && $past(pwr_save)) |-> (!cp_oe && !pump_up && !pump_dn && lock_q));

    // R10: the discarded comparison leaves the flag untouched
    assert_discard_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (discard && !pwr_save) |=> (lock_q == $past(lock_q)));
endmodule

bind phase_lock_cmp phase_lock_cmp_chk #(
    .UNLOCK_TH(UNLOCK_TH), .LOCK_CYC(LOCK_CYC), .GOOD_W(GOOD_W)
) u_chk (
    .clk(clk), .rst(rst), .fr_in(fr_in), .fp_in(fp_in),
    .pol_fc(pol_fc), .mon_sel(mon_sel), .pwr_save(pwr_save),
    .pump_up(pump_up), .pump_dn(pump_dn), .cp_oe(cp_oe), .ld_mon(ld_mon),
    .overdue(overdue), .discard(discard), .lock_q(lock_flag),
    .good_cnt(good_cnt)
);

// File: tb/tb_phase_lock_cmp.sv
module tb_phase_lock_cmp;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fr_in = 1'b0, fp_in = 1'b0, pol_fc = 1'b1, mon_sel = 1'b0;
    logic pwr_save = 1'b0, cs_in = 1'b0;
    logic pump_up, pump_dn, cp_oe, cp_lvl, ld_mon, cs_out;

    always #4 clk = ~clk;

    phase_lock_cmp dut (
        .clk(clk), .rst(rst), .fr_in(fr_in), .fp_in(fp_in), .pol_fc(pol_fc),
        .mon_sel(mon_sel), .pwr_save(pwr_save), .cs_in(cs_in),
        .pump_up(pump_up), .pump_dn(pump_dn), .cp_oe(cp_oe), .cp_lvl(cp_lvl),
        .ld_mon(ld_mon), .cs_out(cs_out)
    );

    // pulse kinds: 1 pin high, 2 pin low, 3 dead-zone (both switches, pin floating)
    typedef struct {
        int    kind;
        int    width;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: measure each pump pulse and compare with the scoreboard queue
    initial begin
        int run_kind;
        int run_len;
        run_kind = 0;
        run_len  = 0;
        forever begin
            int cur;
            @(negedge clk);
            if (rst)                       cur = 0;
            else if (pump_up && pump_dn)   cur = 3;
            else if (cp_oe)                cur = cp_lvl ? 1 : 2;
            else                           cur = 0;
            if (cur == run_kind && cur != 0) begin
                run_len++;
            end else begin
                if (run_kind != 0) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R9/R10 unexpected pump pulse", run_kind * 100 + run_len, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(e.kind == run_kind && e.width == run_len, e.tag,
                            run_kind * 100 + run_len, e.kind * 100 + e.width);
                    end
                end
                run_kind = cur;
                run_len  = (cur != 0) ? 1 : 0;
            end
        end
    end

    // driver: one comparison, lead pulse first, lag pulse k clocks later
    task automatic cmp(input bit fr_first, input int k, input bit expect_pulse, input string tag);
        if (expect_pulse) begin
            exp_t e;
            e.tag   = tag;
            e.width = (k == 0) ? 1 : k;
            e.kind  = (k == 0) ? 3 : ((fr_first == pol_fc) ? 1 : 2);
            q.push_back(e);
        end
        @(negedge clk);
        if (k == 0) begin
            fr_in = 1'b1; fp_in = 1'b1;
            @(negedge clk);
            fr_in = 1'b0; fp_in = 1'b0;
        end else begin
            if (fr_first) fr_in = 1'b1; else fp_in = 1'b1;
            @(negedge clk);
            fr_in = 1'b0; fp_in = 1'b0;
            repeat (k - 1) @(negedge clk);
            if (fr_first) fp_in = 1'b1; else fr_in = 1'b1;
            @(negedge clk);
            fr_in = 1'b0; fp_in = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic push_exp(input int kind, input int width, input string tag);
        exp_t e;
        e.kind = kind; e.width = width; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ld_mon == 1'b0, "R6 lock flag after reset", ld_mon, 0);
        chk(cp_oe == 1'b0, "R4 pin floats after reset", cp_oe, 0);

        // first lock run
        cmp(1'b1, 2, 1'b1, "R1 reference leads by 2");
        cmp(1'b0, 1, 1'b1, "R1 feedback leads by 1");
        chk(ld_mon == 1'b0, "R8 no lock after two good comparisons", ld_mon, 0);
        cmp(1'b1, 0, 1'b1, "R3 same-clock arrival");
        chk(ld_mon == 1'b1, "R8 lock after three good comparisons", ld_mon, 1);
        chk(cp_oe == 1'b0, "R4 pin floats between comparisons", cp_oe, 0);

        // early unlock while the lead is still pending
        push_exp(1, 5, "R7 reference leads by 5");
        @(negedge clk); fr_in = 1'b1;
        @(negedge clk); fr_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(ld_mon == 1'b1, "R7 flag held at lead of 2", ld_mon, 1);
        @(negedge clk);
        chk(ld_mon == 1'b0, "R7 flag cleared at lead of 3", ld_mon, 0);
        @(negedge clk); fp_in = 1'b1;
        @(negedge clk); fp_in = 1'b0;
        repeat (4) @(negedge clk);

        // relock with a restart in the middle
        cmp(1'b1, 1, 1'b1, "R8 run A1");
        cmp(1'b1, 1, 1'b1, "R8 run A2");
        cmp(1'b0, 3, 1'b1, "R8 breaking error of 3");
        cmp(1'b1, 1, 1'b1, "R8 run B1");
        cmp(1'b0, 2, 1'b1, "R8 run B2");
        chk(ld_mon == 1'b0, "R8 count restarted by error of 3", ld_mon, 0);
        cmp(1'b1, 1, 1'b1, "R8 run B3");
        chk(ld_mon == 1'b1, "R8 relocked after restart", ld_mon, 1);

        // inverted polarity
        pol_fc = 1'b0;
        cmp(1'b1, 2, 1'b1, "R2 reference leads, inverted");
        cmp(1'b0, 3, 1'b1, "R2 feedback leads, inverted");
        chk(ld_mon == 1'b0, "R7 error of 3 clears flag", ld_mon, 0);

        // monitor selection
        mon_sel = 1'b1;
        pol_fc  = 1'b1;
        push_exp(1, 3, "R5 window with reference monitor");
        @(negedge clk); fr_in = 1'b1;
        @(negedge clk);
        chk(ld_mon == 1'b1, "R5 monitor shows reference pulse", ld_mon, 1);
        fr_in = 1'b0;
        @(negedge clk);
        chk(ld_mon == 1'b0, "R5 monitor reference pulse ends", ld_mon, 0);
        @(negedge clk); fp_in = 1'b1;
        @(negedge clk);
        chk(ld_mon == 1'b0, "R5 feedback hidden when reference shown", ld_mon, 0);
        fp_in = 1'b0;
        repeat (4) @(negedge clk);
        pol_fc = 1'b0;
        push_exp(2, 3, "R5 window with feedback monitor");
        @(negedge clk); fr_in = 1'b1;
        @(negedge clk);
        chk(ld_mon == 1'b0, "R5 reference hidden when feedback shown", ld_mon, 0);
        fr_in = 1'b0;
        @(negedge clk);
        @(negedge clk); fp_in = 1'b1;
        @(negedge clk);
        chk(ld_mon == 1'b1, "R5 monitor shows feedback pulse", ld_mon, 1);
        fp_in = 1'b0;
        repeat (4) @(negedge clk);
        mon_sel = 1'b0;
        pol_fc  = 1'b1;

        // repeated reference during a lead
        push_exp(1, 4, "R12 window spans repeated reference");
        @(negedge clk); fr_in = 1'b1;
        @(negedge clk); fr_in = 1'b0;
        @(negedge clk); fr_in = 1'b1;
        @(negedge clk); fr_in = 1'b0;
        @(negedge clk); fp_in = 1'b1;
        @(negedge clk); fp_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(ld_mon == 1'b0, "R12 error of 4 leaves flag low", ld_mon, 0);

        // power save and the discarded wake-up comparison
        @(negedge clk); pwr_save = 1'b1;
        @(negedge clk);
        chk(ld_mon == 1'b1, "R9 flag forced high in save", ld_mon, 1);
        chk(cp_oe == 1'b0, "R9 pin floats in save", cp_oe, 0);
        cmp(1'b1, 2, 1'b0, "R9 comparison ignored in save");
        @(negedge clk); pwr_save = 1'b0;
        repeat (2) @(negedge clk);
        chk(ld_mon == 1'b1, "R9 flag still high after release", ld_mon, 1);
        cmp(1'b1, 4, 1'b0, "R10 first comparison discarded");
        chk(ld_mon == 1'b1, "R10 discarded error leaves flag", ld_mon, 1);
        cmp(1'b1, 4, 1'b1, "R10 second comparison acts");
        chk(ld_mon == 1'b0, "R10 second comparison clears flag", ld_mon, 0);

        // current select pass-through
        cs_in = 1'b1;
        #1;
        chk(cs_out == 1'b1, "R11 current select high", cs_out, 1);
        cs_in = 1'b0;
        #1;
        chk(cs_out == 1'b0, "R11 current select low", cs_out, 0);

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R1 all expected pulses seen", q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule